// File: doc/BRIEF.md
# Page-Buffered Self-Timed Write Sequencer

This block sits behind the serial command decoder of a small nonvolatile memory. When a write command starts, it takes the decoded start address and stores each following data byte in a page buffer. Each byte goes to the slot given by the running in-page offset, and that offset wraps at the page edge. The decoder supplies a protection verdict with each byte. A byte whose target address is protected is dropped. A slot that was never written keeps its mask bit at zero.

The transaction ends when chip select rises. A clean byte boundary, a write-enable latch that was set at command start and at least one accepted byte together start a self-timed programming interval. During that interval the block reports busy. It sends the marked slots, one per clock and in ascending order, to an external memory write port. At the end of the interval it pulses a clear request for the write enable latch. New commands that arrive while busy have no effect. The length of the interval is a parameter counted in system clocks, so a test can make it short.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `wip`, `mem_we` and `wel_clr` are all 0.
- R2: Byte k of a transaction (counting from 0) is stored in page slot (start offset + k) mod PAGE_BYTES of the page that holds the start address. When more than PAGE_BYTES bytes arrive, the later bytes overwrite earlier slots, and the last byte written to a slot is the value committed.
- R3: `wip` rises in the cycle after the one where `cs_rise` is sampled high, and only if every commit condition holds.
- R4: `wip` stays at 1 for exactly CYCLE_CLKS consecutive cycles and then returns to 0.
- R5: Only slots that received an accepted byte are written. They are written one per cycle in ascending slot order while `wip` is high. Every address written lies inside the start page.
- R6: A byte presented with `byte_prot` = 1 is discarded, and the memory location it targets keeps its old value.
- R7: If `wel` is 0 when `wr_start` is sampled, the transaction writes nothing, and neither `wip` nor `wel_clr` is raised.
- R8: While `wip` is 1, `wr_start`, `byte_vld` and `cs_rise` have no effect. No memory contents change because of them, and no second cycle follows.
- R9: If `bit_partial` is 1 together with `cs_rise`, the transaction is abandoned, with no write, no `wip` and no `wel_clr`.
- R10: `wel_clr` is high for exactly one cycle, the first cycle in which `wip` is 0 again after a programming interval, and it is never high at any other time.
- R11: A transaction that ends with no accepted byte (no bytes at all, or all of them protected) starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Single-cycle strobe: a write command with its address has been decoded |
| wr_addr | input | ADDR_W | Start address of the write command |
| wel | input | 1 | Current state of the write enable latch |
| byte_vld | input | 1 | Single-cycle strobe: a complete data byte has arrived |
| byte_data | input | 8 | The data byte |
| byte_prot | input | 1 | The address this byte targets is block protected |
| cs_rise | input | 1 | Single-cycle strobe: chip select has risen |
| bit_partial | input | 1 | The bit counter is not on a byte boundary |
| wip | output | 1 | Programming interval in progress |
| mem_we | output | 1 | Memory array write strobe |
| mem_addr | output | ADDR_W | Memory array write address |
| mem_wdata | output | 8 | Memory array write data |
| wel_clr | output | 1 | One-cycle request to clear the write enable latch |

## Verification
Some properties are checked on every cycle. Memory writes occur only inside the busy window, and their page stays fixed. Each busy run lasts exactly CYCLE_CLKS cycles, measured by a run counter. The latch-clear pulse coincides with the falling busy flag. Busy can only start right after a clean chip-select rise. Other behaviour needs whole transactions, so only the bench scenarios can show it: which slots end up committed, the wrap and overwrite order, protected bytes being dropped, and commands issued during the busy window being ignored. The bench compares a mirror of the written array against a model built from the requirements, for random and directed transactions.

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  parameter int CYCLE_CLKS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wel,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              byte_prot,
  input  logic              cs_rise,
  input  logic              bit_partial,
  output logic              wip,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              wel_clr
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_PROG} st_t;

  st_t                   st;
  logic [PG_W-1:0]       pg;
  logic [OFF_W-1:0]      off;
  logic [PAGE_BYTES-1:0] mask;
  logic [7:0]            lat [PAGE_BYTES];
  logic [CNT_W-1:0]      cnt;
  logic                  clr_q;

  wire [OFF_W-1:0] slot    = cnt[OFF_W-1:0];
  wire             in_span = cnt < CNT_W'(PAGE_BYTES);
  wire             take    = (st == S_FILL) && !cs_rise && byte_vld && !byte_prot;

  assign wip       = (st == S_PROG);
  assign mem_we    = wip && in_span && mask[slot];
  assign mem_addr  = {pg, slot};
  assign mem_wdata = lat[slot];
  assign wel_clr   = clr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pg    <= '0;
      off   <= '0;
      mask  <= '0;
      cnt   <= '0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      case (st)
        S_IDLE: if (wr_start && wel) begin
          st   <= S_FILL;
          pg   <= wr_addr[ADDR_W-1:OFF_W];
          off  <= wr_addr[OFF_W-1:0];
          mask <= '0;
        end
        S_FILL: if (cs_rise) begin
          if (!bit_partial && |mask) begin
            st  <= S_PROG;
            cnt <= '0;
          end else begin
            st <= S_IDLE;
          end
        end else if (byte_vld) begin
          off <= off + 1'b1;
          if (!byte_prot) mask[off] <= 1'b1;
        end
        S_PROG: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(CYCLE_CLKS - 1)) begin
            st    <= S_IDLE;
            clr_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (take) lat[off] <= byte_data;

  logic [CNT_W:0] run_len;
  always_ff @(posedge clk)
    if (!rst_n) run_len <= '0;
    else        run_len <= wip ? run_len + 1'b1 : '0;

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!wip && !mem_we && !wel_clr));

  p_start_on_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_rise && !bit_partial));

  p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> run_len < (CNT_W+1)'(CYCLE_CLKS));

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> run_len == (CNT_W+1)'(CYCLE_CLKS));

  p_we_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wip);

  p_page_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip)) |-> mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]));

  p_no_start_partial_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_partial && !wip) |=> !wip);

  p_clr_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> $fell(wip));

  p_end_gives_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> wel_clr);
endmodule

// File: tb/tb_page_write_seq.sv
module tb_page_write_seq;
  localparam int ADDR_W = 11;
  localparam int PB     = 16;
  localparam int CYC    = 40;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_start = 1'b0, wel = 1'b0, byte_vld = 1'b0, byte_prot = 1'b0;
  logic cs_rise = 1'b0, bit_partial = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] byte_data = '0;
  logic wip, mem_we, wel_clr;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;

  always #4 clk = ~clk;

  page_write_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB), .CYCLE_CLKS(CYC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr), .wel(wel),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_prot(byte_prot),
    .cs_rise(cs_rise), .bit_partial(bit_partial), .wip(wip), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wel_clr(wel_clr));

  logic [7:0] img [MEMSZ];
  logic [7:0] mdl [MEMSZ];
  int vec = 0, fails = 0;
  int wr_cnt = 0, clr_cnt = 0, ord_err = 0, prev_slot = -1;
  int cur_page = 0;

  always @(posedge clk) begin
    if (mem_we) begin
      img[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
      if (int'(mem_addr[ADDR_W-1:4]) != cur_page || int'(mem_addr[3:0]) <= prev_slot)
        ord_err <= ord_err + 1;
      prev_slot <= int'(mem_addr[3:0]);
    end
    if (wel_clr) clr_cnt <= clr_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vec++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [PB-1:0] m);
    int c = 0;
    for (int i = 0; i < PB; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic txn(input int a, input int n, input bit en, input bit part,
                     input int pbase, input bit poke);
    logic [7:0] ed [PB];
    logic [PB-1:0] em = '0;
    int wr0, clr0, len, bad, page;
    bit commit;
    page = a / PB;
    wr0 = wr_cnt; clr0 = clr_cnt;
    cur_page = page; prev_slot = -1; ord_err = 0;
    @(negedge clk);
    wr_start = 1'b1; wr_addr = ADDR_W'(a); wel = en;
    @(negedge clk);
    wr_start = 1'b0; wel = 1'b0;
    for (int i = 0; i < n; i++) begin
      int s, ad;
      logic [7:0] d;
      s = (a + i) % PB;
      ad = page * PB + s;
      d = 8'($urandom);
      byte_vld = 1'b1; byte_data = d; byte_prot = (ad >= pbase);
      if (en && ad < pbase) begin ed[s] = d; em[s] = 1'b1; end
      @(negedge clk);
      byte_vld = 1'b0; byte_prot = 1'b0;
      if ($urandom % 3 == 0) @(negedge clk);
    end
    cs_rise = 1'b1; bit_partial = part;
    @(negedge clk);
    cs_rise = 1'b0; bit_partial = 1'b0;
    commit = en && !part && (em != '0);
    chk(wip == commit, "R3 busy after cs rise (R7/R9/R11 gating)", int'(wip), int'(commit));
    if (commit) begin
      len = 0;
      while (wip && len < 4 * CYC) begin
        len++;
        if (poke) begin
          wr_start = (len == 2); wel = (len == 2);
          wr_addr = ADDR_W'((page + 3) * PB % MEMSZ);
          byte_vld = (len == 3) || (len == 4); byte_data = 8'hA5;
          cs_rise = (len == 6);
        end
        @(negedge clk);
      end
      wr_start = 1'b0; wel = 1'b0; byte_vld = 1'b0; cs_rise = 1'b0;
      chk(len == CYC, "R4 busy window length", len, CYC);
      chk(wel_clr == 1'b1, "R10 clear pulse at busy fall", int'(wel_clr), 1);
      @(negedge clk);
      chk(wel_clr == 1'b0, "R10 clear pulse width", int'(wel_clr), 0);
      repeat (3) @(negedge clk);
      chk(wip == 1'b0, "R8 no second cycle after busy poke", int'(wip), 0);
      chk(clr_cnt - clr0 == 1, "R10 clear pulse count", clr_cnt - clr0, 1);
      for (int s = 0; s < PB; s++) if (em[s]) mdl[page * PB + s] = ed[s];
    end else begin
      repeat (CYC / 4) @(negedge clk);
      chk(wip == 1'b0, "R9/R11 no cycle started", int'(wip), 0);
      chk(clr_cnt == clr0, "R7/R9 no clear pulse", clr_cnt - clr0, 0);
    end
    chk(wr_cnt - wr0 == (commit ? popc(em) : 0), "R5 only written slots committed",
        wr_cnt - wr0, commit ? popc(em) : 0);
    chk(ord_err == 0, "R5 ascending in-page write order", ord_err, 0);
    bad = -1;
    for (int k = 0; k < MEMSZ; k++) if (bad < 0 && img[k] !== mdl[k]) bad = k;
    if (bad < 0) chk(1'b1, "R2/R6/R8 array image", 0, 0);
    else chk(1'b0, $sformatf("R2/R6/R8 array image at %0d", bad), int'(img[bad]), int'(mdl[bad]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < MEMSZ; k++) begin img[k] = 8'h00; mdl[k] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wip && !mem_we && !wel_clr, "R1 reset outputs idle",
        int'({wip, mem_we, wel_clr}), 0);
    txn(32, 4, 1, 0, MEMSZ, 0);
    txn(14 + 5 * PB, 5, 1, 0, MEMSZ, 0);
    txn(3 + 9 * PB, 20, 1, 0, MEMSZ, 0);
    txn(40 * PB, 6, 0, 0, MEMSZ, 0);
    txn(41 * PB, 6, 1, 1, MEMSZ, 0);
    txn(42 * PB, 0, 1, 0, MEMSZ, 0);
    txn(MEMSZ / 2 + 4, 6, 1, 0, MEMSZ / 2, 0);
    txn(MEMSZ / 2 - 4, 8, 1, 0, MEMSZ / 2, 0);
    txn(MEMSZ - PB, 16, 1, 0, MEMSZ, 1);
    txn(7 * PB + 2, 3, 1, 0, MEMSZ, 1);
    for (int t = 0; t < 60; t++) begin
      int a, n, pb;
      bit en, part;
      a = int'($urandom % MEMSZ);
      n = int'($urandom % 24);
      en = ($urandom % 6) != 0;
      part = ($urandom % 8) == 0;
      case ($urandom % 4)
        0: pb = 0;
        1: pb = MEMSZ / 2;
        2: pb = 3 * MEMSZ / 4;
        default: pb = MEMSZ;
      endcase
      txn(a, n, en, part, pb, ($urandom % 3) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end
endmodule